// File: doc/BRIEF.md
# Cassette Controller Register Interface

This block is the bus-facing register interface of a two-drive cassette tape controller. It holds one 16-bit control/status word and one data-buffer port, with address bit 1 choosing between them. The control/status word can be written as a whole word or one byte at a time. The word carries the software-owned control fields: drive select, interrupt enable, CRC-sequence request and a 3-bit command code. It also carries status bits, which only the tape sequencer can set. The bus cannot set them.

A write with the go bit set, while the sequencer is idle, clears the status bits and sends a one-cycle start pulse to the sequencer. The sequencer reports its results on set-strobes. It asks for each data byte through a transfer-request flag, and the processor services that flag by reading or writing the data buffer. When a new request arrives before the previous one has been serviced, the block does not raise the request again. It sets error and timing instead. A level interrupt is raised while interrupts are enabled and either the transfer request or ready is up.

Top module: `cas_csr_if`

## Requirements
- R1: After reset the CSR reads 0x0020 (only ready, bit 5, set). The data buffer reads 0x0000, `out_byte_o` is 0 and `irq_o` is low.
- R2: A CSR write changes only the writable fields. These are drive select (bit 8), interrupt enable (bit 6), CRC sequence (bit 4) and command (bits 3:1). Go (bit 0) always reads 0.
- R3: A byte write takes its data from `bus_wdata_i[7:0]`. At the odd address (`bus_addr_i[0]`=1) it replaces CSR bits 15:8 and keeps 7:0. At the even address it replaces 7:0 and keeps 15:8. A word write (`bus_byte_i`=0) uses all 16 bits.
- R4: A CSR write whose merged bit 0 is 1, while `seq_busy_i` is low, raises `go_o` for exactly the following cycle. It also clears bits 15:9, 7 and 5. While busy, no pulse is produced and no status bit is cleared. An odd-byte write can never start a command.
- R5: A data-buffer read returns {8'h00, input byte} and clears the transfer request (bit 7). A word or even-byte data-buffer write loads `out_byte_o` and clears the request. An odd-byte data-buffer write changes nothing.
- R6: A CSR write that leaves bit 4 set clears the transfer request. A write with bit 4 clear leaves the request as it was.
- R7: `seq_xfer_req_i` sets bit 7 when the request is clear after this cycle's bus clears. If the request is still set, the strobe instead sets error (bit 15) and timing (bit 10), and bit 7 stays set.
- R8: `irq_o` is high exactly when bit 6 is set and bit 7 or bit 5 is set.
- R9: Each bit of `seq_set_i` sets one sticky CSR bit: 0 error (15), 1 CRC (14), 2 BOT/EOT (13), 3 write lock (12), 4 end of file (11), 5 timing (10), 6 empty (9), 7 ready (5). The bit stays set until a start or a reset. A strobe in the same cycle as a start wins.
- R10: `seq_in_load_i` loads `seq_in_byte_i` into the input byte returned by data-buffer reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Bus write strobe |
| bus_rd_i | input | 1 | Bus read strobe (side effects on data buffer) |
| bus_addr_i | input | 2 | Bit 1 selects data buffer, bit 0 selects odd byte |
| bus_byte_i | input | 1 | Byte access |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| seq_busy_i | input | 1 | Sequencer has a command in progress |
| seq_set_i | input | 8 | Status set-strobes |
| seq_xfer_req_i | input | 1 | Sequencer asks for a byte transfer |
| seq_in_load_i | input | 1 | Load input byte |
| seq_in_byte_i | input | 8 | Byte read from tape |
| go_o | output | 1 | One-cycle command start pulse |
| unit_o | output | 1 | Selected drive |
| func_o | output | 3 | Command code |
| crc_seq_o | output | 1 | CRC sequence requested |
| out_byte_o | output | 8 | Byte to be written to tape |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The bench drives a second transfer request while the first is unserviced, and expects error and timing with the request left set. A design that re-raises the request silently would lose that overrun. It also issues a data-buffer read in the same cycle as a new request, where the clear must come first. A design that checked the stale flag there would report a false timing error. Odd-byte accesses are run on both registers: an odd CSR byte carrying bit 0 must not start a command, and an odd data-buffer write must not load the byte or clear the request. A status strobe coinciding with a start is expected to survive, where a design with the wrong priority would drop ready.

// File: rtl/cas_csr_pkg.sv
package cas_csr_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CSR_W  = 2 * BYTE_W;
  localparam int unsigned N_STS  = 8;
  // status strobe indices
  localparam int unsigned S_ERR  = 0;
  localparam int unsigned S_CRC  = 1;
  localparam int unsigned S_BEOT = 2;
  localparam int unsigned S_WLK  = 3;
  localparam int unsigned S_EOF  = 4;
  localparam int unsigned S_TIM  = 5;
  localparam int unsigned S_EMP  = 6;
  localparam int unsigned S_RDY  = 7;
  // CSR bit positions (software-visible layout)
  localparam int unsigned B_GO   = 0;
  localparam int unsigned B_FNLO = 1;
  localparam int unsigned B_CSEQ = 4;
  localparam int unsigned B_RDY  = 5;
  localparam int unsigned B_IE   = 6;
  localparam int unsigned B_TR   = 7;
  localparam int unsigned B_UNIT = 8;
  localparam int unsigned FN_W   = 3;
endpackage

// File: rtl/cas_csr_merge.sv
module cas_csr_merge #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] wdata_i,
  input  logic         byte_i,
  input  logic         odd_i,
  output logic [W-1:0] merged_o
);
  localparam int unsigned H = W / 2;

  always_comb begin
    if (!byte_i)     merged_o = wdata_i;
    else if (odd_i)  merged_o = {wdata_i[H-1:0], cur_i[H-1:0]};
    else             merged_o = {cur_i[W-1:H], wdata_i[H-1:0]};
  end
endmodule

// File: rtl/cas_csr_xfer.sv
module cas_csr_xfer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic req_i,
  output logic tr_o,
  output logic tim_o
);
  logic tr_q, tr_kept;

  // bus clears act before the new request is judged
  assign tr_kept = tr_q & ~clr_i;
  assign tim_o   = req_i & tr_kept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tr_q <= 1'b0;
    else         tr_q <= tr_kept | req_i;
  end

  assign tr_o = tr_q;
endmodule

// File: rtl/cas_csr_status.sv
module cas_csr_status #(
  parameter int unsigned N = 8,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] sts_o
);
  logic [N-1:0] sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= RST_VAL;
    else         sts_q <= (clr_i ? '0 : sts_q) | set_i;
  end

  assign sts_o = sts_q;
endmodule

// File: rtl/cas_csr_if.sv
module cas_csr_if
  import cas_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [1:0]        bus_addr_i,
  input  logic              bus_byte_i,
  input  logic [CSR_W-1:0]  bus_wdata_i,
  output logic [CSR_W-1:0]  bus_rdata_o,
  input  logic              seq_busy_i,
  input  logic [N_STS-1:0]  seq_set_i,
  input  logic              seq_xfer_req_i,
  input  logic              seq_in_load_i,
  input  logic [BYTE_W-1:0] seq_in_byte_i,
  output logic              go_o,
  output logic              unit_o,
  output logic [FN_W-1:0]   func_o,
  output logic              crc_seq_o,
  output logic [BYTE_W-1:0] out_byte_o,
  output logic              irq_o
);
  localparam logic [N_STS-1:0] STS_RST = N_STS'(1) << S_RDY;

  logic              csr_wr, db_rd, db_wr_lo, start;
  logic [CSR_W-1:0]  csr_q, merged;
  logic [N_STS-1:0]  sts, sts_set;
  logic              tr, tim, tr_clr;
  logic              unit_q, ie_q, cseq_q, go_q;
  logic [FN_W-1:0]   fn_q;
  logic [BYTE_W-1:0] in_q, out_q;

  assign csr_wr   = bus_wr_i & ~bus_addr_i[1];
  assign db_rd    = bus_rd_i &  bus_addr_i[1];
  assign db_wr_lo = bus_wr_i &  bus_addr_i[1] & ~(bus_byte_i & bus_addr_i[0]);

  assign csr_q = {sts[S_ERR], sts[S_CRC], sts[S_BEOT], sts[S_WLK], sts[S_EOF],
                  sts[S_TIM], sts[S_EMP], unit_q, tr, ie_q, sts[S_RDY], cseq_q,
                  fn_q, 1'b0};

  cas_csr_merge #(.W(CSR_W)) u_merge (
    .cur_i   (csr_q),
    .wdata_i (bus_wdata_i),
    .byte_i  (bus_byte_i),
    .odd_i   (bus_addr_i[0]),
    .merged_o(merged)
  );

  assign start  = csr_wr & merged[B_GO] & ~seq_busy_i;
  assign tr_clr = start | db_rd | db_wr_lo | (csr_wr & merged[B_CSEQ]);

  cas_csr_xfer u_xfer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (tr_clr),
    .req_i (seq_xfer_req_i),
    .tr_o  (tr),
    .tim_o (tim)
  );

  always_comb begin
    sts_set        = seq_set_i;
    sts_set[S_ERR] = seq_set_i[S_ERR] | tim;
    sts_set[S_TIM] = seq_set_i[S_TIM] | tim;
  end

  cas_csr_status #(.N(N_STS), .RST_VAL(STS_RST)) u_sts (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start),
    .set_i (sts_set),
    .sts_o (sts)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unit_q <= 1'b0;
      ie_q   <= 1'b0;
      cseq_q <= 1'b0;
      fn_q   <= '0;
      go_q   <= 1'b0;
      in_q   <= '0;
      out_q  <= '0;
    end else begin
      go_q <= start;
      if (csr_wr) begin
        unit_q <= merged[B_UNIT];
        ie_q   <= merged[B_IE];
        cseq_q <= merged[B_CSEQ];
        fn_q   <= merged[B_FNLO +: FN_W];
      end
      if (seq_in_load_i) in_q  <= seq_in_byte_i;
      if (db_wr_lo)      out_q <= bus_wdata_i[BYTE_W-1:0];
    end
  end

  assign bus_rdata_o = bus_addr_i[1] ? {{(CSR_W-BYTE_W){1'b0}}, in_q} : csr_q;
  assign go_o        = go_q;
  assign unit_o      = unit_q;
  assign func_o      = fn_q;
  assign crc_seq_o   = cseq_q;
  assign out_byte_o  = out_q;
  assign irq_o       = ie_q & (tr | sts[S_RDY]);
endmodule

// File: rtl/cas_csr_if_chk.sv
module cas_csr_if_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_wr_i,
  input logic        bus_rd_i,
  input logic [1:0]  bus_addr_i,
  input logic        bus_byte_i,
  input logic [15:0] bus_wdata_i,
  input logic [15:0] bus_rdata_o,
  input logic        seq_busy_i,
  input logic [7:0]  seq_set_i,
  input logic        seq_xfer_req_i,
  input logic        go_o,
  input logic [7:0]  out_byte_o,
  input logic        irq_o,
  input logic [15:0] csr_q
);
  assert_irq_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_addr_i[1] |-> irq_o == (bus_rdata_o[6] & (bus_rdata_o[7] | bus_rdata_o[5])));

  assert_go_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && !bus_addr_i[1] && seq_busy_i) |=> !go_o);

  assert_go_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == 2'b00 && !bus_byte_i && bus_wdata_i[0] && !seq_busy_i &&
     seq_set_i == 8'h00 && !seq_xfer_req_i)
    |=> go_o && csr_q[15:9] == 7'h00 && !csr_q[7] && !csr_q[5]);

  assert_go_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_o |=> !go_o || $past(bus_wr_i));

  assert_db_read_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i[1] && !seq_xfer_req_i) |=> !csr_q[7]);

  assert_db_odd_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == 2'b11 && bus_byte_i) |=> $stable(out_byte_o));

  assert_cseq_clr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == 2'b00 && !bus_byte_i && bus_wdata_i[4] && !seq_xfer_req_i)
    |=> !csr_q[7]);

  assert_timing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_xfer_req_i && csr_q[7] && !bus_wr_i && !bus_rd_i)
    |=> csr_q[15] && csr_q[10] && csr_q[7]);

  assert_sts_not_bus_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_set_i == 8'h00 && !seq_xfer_req_i)
    |=> (csr_q[15:9] & ~$past(csr_q[15:9])) == 7'h00);
endmodule

bind cas_csr_if cas_csr_if_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_wr_i      (bus_wr_i),
  .bus_rd_i      (bus_rd_i),
  .bus_addr_i    (bus_addr_i),
  .bus_byte_i    (bus_byte_i),
  .bus_wdata_i   (bus_wdata_i),
  .bus_rdata_o   (bus_rdata_o),
  .seq_busy_i    (seq_busy_i),
  .seq_set_i     (seq_set_i),
  .seq_xfer_req_i(seq_xfer_req_i),
  .go_o          (go_o),
  .out_byte_o    (out_byte_o),
  .irq_o         (irq_o),
  .csr_q         (csr_q)
);

// File: tb/sim_cas_csr_if.sv
`timescale 1ns/1ps
module sim_cas_csr_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 0, bus_rd = 0, bus_byte = 0;
  logic [1:0]  bus_addr = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic        seq_busy = 0, seq_xreq = 0, seq_load = 0;
  logic [7:0]  seq_set = 0, seq_inb = 0, out_byte;
  logic        go, unit, cseq, irq;
  logic [2:0]  func;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cas_csr_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_byte_i(bus_byte), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .seq_busy_i(seq_busy), .seq_set_i(seq_set),
    .seq_xfer_req_i(seq_xreq), .seq_in_load_i(seq_load), .seq_in_byte_i(seq_inb),
    .go_o(go), .unit_o(unit), .func_o(func), .crc_seq_o(cseq),
    .out_byte_o(out_byte), .irq_o(irq)
  );

  task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops expected read data as reads happen
  always @(negedge clk) begin
    if (bus_rd && rst_n) begin
      if (exp_q.size() == 0) check(bus_rdata, 16'hxxxx, "scoreboard underrun");
      else check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic step(input logic wr, input logic rd, input logic [1:0] a,
                      input logic by, input logic [15:0] d, input logic [7:0] st,
                      input logic xr);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_byte = by; bus_wdata = d;
    seq_set = st; seq_xreq = xr;
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0; bus_byte = 0; seq_set = 0; seq_xreq = 0; seq_load = 0;
  endtask

  task automatic wr_w(input logic [1:0] a, input logic [15:0] d);
    step(1, 0, a, 0, d, 8'h00, 0);
  endtask
  task automatic wr_b(input logic [1:0] a, input logic [7:0] d);
    step(1, 0, a, 1, {8'h00, d}, 8'h00, 0);
  endtask
  task automatic rd_exp(input logic [1:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    step(0, 1, a, 0, 16'h0, 8'h00, 0);
  endtask
  task automatic xreq();
    step(0, 0, 2'b00, 0, 16'h0, 8'h00, 1);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state
    rd_exp(2'b00, 16'h0020, "R1 csr");
    rd_exp(2'b10, 16'h0000, "R1 dbuf");
    check({8'h0, out_byte}, 16'h0000, "R1 out_byte");
    check({15'h0, irq}, 16'h0000, "R1 irq");
    // R2 only writable fields land
    wr_w(2'b00, 16'hFFFE);
    rd_exp(2'b00, 16'h017E, "R2 writable mask");
    check({15'h0, irq}, 16'h0001, "R8 ie with ready");
    // R3 byte lanes
    wr_b(2'b01, 8'h00);
    rd_exp(2'b00, 16'h007E, "R3 odd byte upper");
    wr_b(2'b00, 8'h08);
    rd_exp(2'b00, 16'h0028, "R3 even byte lower");
    check({15'h0, irq}, 16'h0000, "R8 ie clear");
    // R9 status strobes
    step(0, 0, 2'b00, 0, 16'h0, 8'hFF, 0);
    rd_exp(2'b00, 16'hFE28, "R9 strobes");
    // R4 go while busy
    seq_busy = 1;
    wr_w(2'b00, 16'h0003);
    check({15'h0, go}, 16'h0000, "R4 no go when busy");
    rd_exp(2'b00, 16'hFE22, "R4 busy keeps status");
    seq_busy = 0;
    wr_w(2'b00, 16'h0005);
    check({15'h0, go}, 16'h0001, "R4 go pulse");
    rd_exp(2'b00, 16'h0004, "R4 start clears");
    check({15'h0, go}, 16'h0000, "R4 go one cycle");
    wr_b(2'b01, 8'h01);
    check({15'h0, go}, 16'h0000, "R4 odd byte no go");
    rd_exp(2'b00, 16'h0104, "R3 odd byte unit");
    // R10 input load, R5 read clears request
    seq_inb = 8'hA5; seq_load = 1;
    xreq();
    rd_exp(2'b00, 16'h0184, "R7 request set");
    rd_exp(2'b10, 16'h00A5, "R10 input byte");
    rd_exp(2'b00, 16'h0104, "R5 read clears request");
    // R8 irq from request
    wr_w(2'b00, 16'h0144);
    check({15'h0, irq}, 16'h0000, "R8 ie no source");
    xreq();
    check({15'h0, irq}, 16'h0001, "R8 irq from request");
    // R7 overrun
    xreq();
    rd_exp(2'b00, 16'h85C4, "R7 timing error");
    // R5 data buffer writes
    wr_b(2'b10, 8'h3C);
    check({8'h0, out_byte}, 16'h003C, "R5 even byte load");
    rd_exp(2'b00, 16'h8544, "R5 write clears request");
    xreq();
    wr_b(2'b11, 8'h77);
    check({8'h0, out_byte}, 16'h003C, "R5 odd byte ignored");
    rd_exp(2'b00, 16'h85C4, "R5 odd byte keeps request");
    // R6 CRC sequence
    wr_w(2'b00, 16'h0154);
    rd_exp(2'b00, 16'h8554, "R6 cseq clears request");
    xreq();
    wr_w(2'b00, 16'h0144);
    rd_exp(2'b00, 16'h85C4, "R6 cseq off keeps request");
    // R7 clear and request in the same cycle
    wr_w(2'b00, 16'h0145);
    rd_exp(2'b00, 16'h0144, "R4 start clears errors");
    xreq();
    exp_q.push_back(16'h00A5); tag_q.push_back("R5 read with request");
    step(0, 1, 2'b10, 0, 16'h0, 8'h00, 1);
    rd_exp(2'b00, 16'h01C4, "R7 no false timing");
    // R9 strobe wins over start
    step(1, 0, 2'b00, 0, 16'h0145, 8'h80, 0);
    rd_exp(2'b00, 16'h0164, "R9 strobe beats start");
    check({15'h0, irq}, 16'h0001, "R8 irq from ready");
    // R1 reset mid run
    rst_n = 1'b0; #3; rst_n = 1'b1;
    @(posedge clk); #1;
    rd_exp(2'b00, 16'h0020, "R1 csr after reset");
    check({8'h0, out_byte}, 16'h0000, "R1 out_byte after reset");
    @(posedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule